// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences the entry into a processor exception handler and the return from it. When an exception is requested, it takes a cause code, the faulting PC and a delay-slot flag. From these it computes the PC to save, captures the current status word into a saved-status register, and issues a status write in which the delay-slot-exception bit follows the flag. It also issues a one-cycle redirect to the handler for that cause.

A return request writes the saved status back with the fixed-one bit forced, and redirects to the saved PC. A trap cause does not vector: it raises a one-cycle debug-halt pulse that carries the PC. A cause code the block does not recognise raises an error pulse and changes nothing.

The block also holds the "next instruction is in a delay slot" flag. Entry and return clear it. All results appear as registered pulses one clock after the request.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, `redirect_o`, `sr_we_o`, `halt_o`, `err_o` and `nds_o` are 0, and `epc_o` and `esr_o` are 0.
- R2: On entry with cause 0x0D (floating point) or 0x0C (system call), the saved PC is exc_pc+4 when `exc_ds_i`=0. It is exc_pc when `exc_ds_i`=1.
- R3: On entry with cause 0x02 (bus error), 0x06 (alignment), 0x07 (illegal instruction) or 0x0B (range), the saved PC is exc_pc when `exc_ds_i`=0. It is exc_pc-4 when `exc_ds_i`=1.
- R4: On entry with cause 0x01 (reset), the saved PC keeps its previous value.
- R5: On a vectoring entry, `esr_o` takes the value of `sr_i`. In the same cycle `sr_we_o` pulses with `sr_wdata_o` equal to `sr_i`, with bit 13 (delay-slot exception) replaced by `exc_ds_i`.
- R6: On a vectoring entry, `redirect_pc_o` = base + (cause << 8). The base is 0xF0000000 when bit 14 of `sr_i` (vector prefix) is 1, and 0 otherwise.
- R7: On entry with cause 0x0E (trap), `halt_o` pulses with `halt_pc_o` = exc_pc. There is no redirect, no status write, and no change to `epc_o`, `esr_o` or `nds_o`.
- R8: On entry with any other cause code, `err_o` pulses. There is no redirect, no status write, no halt, and no change to `epc_o`, `esr_o` or `nds_o`.
- R9: On a return, `sr_we_o` pulses with `sr_wdata_o` = `esr_o` with bit 15 (fixed one) set, and `redirect_o` pulses with `redirect_pc_o` = `epc_o`.
- R10: `nds_set_i` sets `nds_o` on the next clock. A vectoring entry or a return clears it, and the clear wins over a simultaneous set.
- R11: When entry and return are requested in the same cycle, only the entry is performed.
- R12: `redirect_o`, `sr_we_o`, `halt_o` and `err_o` are high only in the cycle after a request that produces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception entry request |
| exc_cause_i | input | 5 | Cause code |
| exc_pc_i | input | 32 | PC of the excepting instruction |
| exc_ds_i | input | 1 | Excepting instruction sits in a delay slot |
| rfe_req_i | input | 1 | Return-from-exception request |
| sr_i | input | 32 | Current status word |
| nds_set_i | input | 1 | Mark the next instruction as a delay slot |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| sr_we_o | output | 1 | Status write pulse |
| sr_wdata_o | output | 32 | Status write data |
| halt_o | output | 1 | Debug-halt pulse |
| halt_pc_o | output | 32 | PC reported with the halt |
| err_o | output | 1 | Unrecognised cause pulse |
| epc_o | output | 32 | Saved exception PC |
| esr_o | output | 32 | Saved status word |
| nds_o | output | 1 | Next-instruction-in-delay-slot flag |

## Verification
The bench drives every recognised cause with the delay-slot flag both low and high. This shows whether the block applies the after-instruction or the at-instruction offset, and in which direction the delay-slot correction goes. Status words with the prefix bit set and clear separate the two vector bases. Returns that follow entries of each class show whether the saved PC and saved status written at entry are the ones restored. Collisions of entry with return, of entry with a delay-slot set, and of unknown or trap causes with pending state show priority and that nothing is touched. A long stretch of mixed random requests is then compared against the model on every clock.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;

  localparam logic [CAUSE_W-1:0] C_RESET   = 5'h01;
  localparam logic [CAUSE_W-1:0] C_BUSERR  = 5'h02;
  localparam logic [CAUSE_W-1:0] C_ALIGN   = 5'h06;
  localparam logic [CAUSE_W-1:0] C_ILLEGAL = 5'h07;
  localparam logic [CAUSE_W-1:0] C_RANGE   = 5'h0B;
  localparam logic [CAUSE_W-1:0] C_SYSCALL = 5'h0C;
  localparam logic [CAUSE_W-1:0] C_FPE     = 5'h0D;
  localparam logic [CAUSE_W-1:0] C_TRAP    = 5'h0E;

  typedef enum logic [2:0] {
    CLS_BAD,    // unrecognised
    CLS_RESET,  // saved PC untouched
    CLS_NEXT,   // saved PC points past the instruction
    CLS_AT,     // saved PC points at the instruction
    CLS_TRAP    // debug halt
  } cls_e;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
#(
  parameter int CW = CAUSE_W
) (
  input  logic [CW-1:0] cause_i,
  output cls_e          cls_o
);
  always_comb begin
    unique case (cause_i)
      C_RESET:                                cls_o = CLS_RESET;
      C_FPE, C_SYSCALL:                       cls_o = CLS_NEXT;
      C_BUSERR, C_ALIGN, C_ILLEGAL, C_RANGE:  cls_o = CLS_AT;
      C_TRAP:                                 cls_o = CLS_TRAP;
      default:                                cls_o = CLS_BAD;
    endcase
  end
endmodule

// File: rtl/exc_pc_calc.sv
module exc_pc_calc
  import exc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int ISTEP = 4
) (
  input  cls_e            cls_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ds_i,
  output logic            upd_o,
  output logic [XLEN-1:0] epc_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(ISTEP);

  logic [XLEN-1:0] pc_next, pc_prev;
  assign pc_next = pc_i + STEP;
  assign pc_prev = pc_i - STEP;

  always_comb begin
    upd_o = 1'b0;
    epc_o = pc_i;
    unique case (cls_i)
      CLS_NEXT: begin
        upd_o = 1'b1;
        epc_o = ds_i ? pc_i : pc_next;
      end
      CLS_AT: begin
        upd_o = 1'b1;
        epc_o = ds_i ? pc_prev : pc_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
  parameter int              XLEN      = 32,
  parameter int              CW        = 5,
  parameter int              VEC_SHIFT = 8,
  parameter logic [XLEN-1:0] HIGH_BASE = 32'hF000_0000
) (
  input  logic [CW-1:0]   cause_i,
  input  logic            high_i,
  output logic [XLEN-1:0] addr_o
);
  logic [XLEN-1:0] offs;
  assign offs   = XLEN'(cause_i) << VEC_SHIFT;
  assign addr_o = (high_i ? HIGH_BASE : '0) + offs;
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CW      = CAUSE_W,
  parameter int FO_BIT  = 15,
  parameter int PFX_BIT = 14,
  parameter int DSX_BIT = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_req_i,
  input  logic [CW-1:0]   exc_cause_i,
  input  logic [XLEN-1:0] exc_pc_i,
  input  logic            exc_ds_i,
  input  logic            rfe_req_i,
  input  logic [XLEN-1:0] sr_i,
  input  logic            nds_set_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            sr_we_o,
  output logic [XLEN-1:0] sr_wdata_o,
  output logic            halt_o,
  output logic [XLEN-1:0] halt_pc_o,
  output logic            err_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] esr_o,
  output logic            nds_o
);
  cls_e            cls;
  logic            epc_upd;
  logic [XLEN-1:0] epc_calc, vec_addr;

  exc_decode #(.CW(CW)) u_dec (.cause_i(exc_cause_i), .cls_o(cls));

  exc_pc_calc #(.XLEN(XLEN)) u_pc (
    .cls_i(cls), .pc_i(exc_pc_i), .ds_i(exc_ds_i),
    .upd_o(epc_upd), .epc_o(epc_calc)
  );

  exc_vector #(.XLEN(XLEN), .CW(CW)) u_vec (
    .cause_i(exc_cause_i), .high_i(sr_i[PFX_BIT]), .addr_o(vec_addr)
  );

  logic do_vec, do_trap, do_bad, do_rfe;
  assign do_vec  = exc_req_i && (cls == CLS_RESET || cls == CLS_NEXT || cls == CLS_AT);
  assign do_trap = exc_req_i && (cls == CLS_TRAP);
  assign do_bad  = exc_req_i && (cls == CLS_BAD);
  assign do_rfe  = rfe_req_i && !exc_req_i;  // entry wins

  logic [XLEN-1:0] sr_entry, sr_ret;
  always_comb begin
    sr_entry          = sr_i;
    sr_entry[DSX_BIT] = exc_ds_i;
    sr_ret            = esr_o;
    sr_ret[FO_BIT]    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      sr_we_o       <= 1'b0;
      sr_wdata_o    <= '0;
      halt_o        <= 1'b0;
      halt_pc_o     <= '0;
      err_o         <= 1'b0;
      epc_o         <= '0;
      esr_o         <= '0;
      nds_o         <= 1'b0;
    end else begin
      redirect_o <= do_vec || do_rfe;
      sr_we_o    <= do_vec || do_rfe;
      halt_o     <= do_trap;
      err_o      <= do_bad;
      if (do_vec) begin
        redirect_pc_o <= vec_addr;
        sr_wdata_o    <= sr_entry;
        esr_o         <= sr_i;
        if (epc_upd) epc_o <= epc_calc;
      end else if (do_rfe) begin
        redirect_pc_o <= epc_o;
        sr_wdata_o    <= sr_ret;
      end
      if (do_trap) halt_pc_o <= exc_pc_i;
      if (do_vec || do_rfe) nds_o <= 1'b0;
      else if (nds_set_i)   nds_o <= 1'b1;
    end
  end
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int XLEN = 32,
  parameter int CW   = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_req_i,
  input logic            rfe_req_i,
  input logic [XLEN-1:0] sr_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o,
  input logic            sr_we_o,
  input logic            halt_o,
  input logic            err_o,
  input logic [XLEN-1:0] epc_o,
  input logic [XLEN-1:0] esr_o,
  input logic            nds_o
);
  a_r7_trap_no_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !redirect_o && !sr_we_o && !err_o);

  a_r8_bad_cause_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !redirect_o && !sr_we_o && $stable(epc_o) && $stable(esr_o));

  a_r5_esr_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && $past(exc_req_i)) |-> esr_o == $past(sr_i));

  a_r6_vector_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && $past(exc_req_i)) |-> redirect_pc_o[7:0] == 8'h00);

  a_r9_return_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_req_i && !exc_req_i) |=> redirect_o && redirect_pc_o == $past(epc_o));

  a_r10_nds_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> !nds_o);

  a_r12_write_with_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sr_we_o == redirect_o);
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .exc_req_i(exc_req_i), .rfe_req_i(rfe_req_i),
  .sr_i(sr_i), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
  .sr_we_o(sr_we_o), .halt_o(halt_o), .err_o(err_o), .epc_o(epc_o),
  .esr_o(esr_o), .nds_o(nds_o)
);

// File: tb/tb_exc_ctrl.sv
module tb_exc_ctrl;
  logic        clk = 0, rst_n = 0;
  logic        exc_req = 0, exc_ds = 0, rfe_req = 0, nds_set = 0;
  logic [4:0]  cause = 0;
  logic [31:0] pc = 0, sr = 0;
  logic        redirect, sr_we, halt, err, nds;
  logic [31:0] redirect_pc, sr_wdata, halt_pc, epc, esr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  exc_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .exc_req_i(exc_req), .exc_cause_i(cause),
    .exc_pc_i(pc), .exc_ds_i(exc_ds), .rfe_req_i(rfe_req), .sr_i(sr),
    .nds_set_i(nds_set), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
    .sr_we_o(sr_we), .sr_wdata_o(sr_wdata), .halt_o(halt), .halt_pc_o(halt_pc),
    .err_o(err), .epc_o(epc), .esr_o(esr), .nds_o(nds)
  );

  // reference model
  bit          m_redir, m_we, m_halt, m_err, m_nds;
  logic [31:0] m_rpc, m_wd, m_hpc, m_epc, m_esr;
  string       t_epc, t_rpc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_redir = 0; m_we = 0; m_halt = 0; m_err = 0; m_nds = 0;
      m_rpc = 0; m_wd = 0; m_hpc = 0; m_epc = 0; m_esr = 0;
      t_epc = "R1"; t_rpc = "R1";
    end else begin
      int kind;  // 0 none 1 reset 2 next 3 at 4 trap 5 bad
      kind = 0;
      if (exc_req) begin
        case (cause)
          5'h01: kind = 1;
          5'h0C, 5'h0D: kind = 2;
          5'h02, 5'h06, 5'h07, 5'h0B: kind = 3;
          5'h0E: kind = 4;
          default: kind = 5;
        endcase
      end
      m_redir = 0; m_we = 0; m_halt = 0; m_err = 0;
      if (kind >= 1 && kind <= 3) begin
        m_redir = 1; m_we = 1;
        m_rpc = (sr[14] ? 32'hF000_0000 : 32'h0) + ({27'd0, cause} * 256);
        m_wd = sr; m_wd[13] = exc_ds;
        m_esr = sr;
        if (kind == 2) begin m_epc = exc_ds ? pc : pc + 4; t_epc = "R2"; end
        else if (kind == 3) begin m_epc = exc_ds ? pc - 4 : pc; t_epc = "R3"; end
        else t_epc = "R4";
        t_rpc = "R6";
        m_nds = 0;
      end else if (kind == 4) begin
        m_halt = 1; m_hpc = pc;
        if (nds_set) m_nds = 1;
      end else if (kind == 5) begin
        m_err = 1;
        if (nds_set) m_nds = 1;
      end else if (rfe_req) begin
        m_redir = 1; m_we = 1; m_rpc = m_epc;
        m_wd = m_esr | 32'h0000_8000;
        t_rpc = "R9";
        m_nds = 0;
      end else if (nds_set) m_nds = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R12 redirect", {31'd0, redirect}, {31'd0, m_redir});
    chk("R12 sr_we", {31'd0, sr_we}, {31'd0, m_we});
    chk("R7 halt", {31'd0, halt}, {31'd0, m_halt});
    chk("R8 err", {31'd0, err}, {31'd0, m_err});
    chk("R10 nds", {31'd0, nds}, {31'd0, m_nds});
    chk({t_epc, " epc"}, epc, m_epc);
    chk("R5 esr", esr, m_esr);
    if (m_redir) chk({t_rpc, " redirect_pc"}, redirect_pc, m_rpc);
    if (m_we) chk("R5/R9 sr_wdata", sr_wdata, m_wd);
    if (m_halt) chk("R7 halt_pc", halt_pc, m_hpc);
  endtask

  task automatic step(input bit e, input logic [4:0] c, input logic [31:0] p,
                      input bit d, input bit r, input logic [31:0] s, input bit n);
    exc_req = e; cause = c; pc = p; exc_ds = d; rfe_req = r; sr = s; nds_set = n;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 redirect", {31'd0, redirect}, 32'd0);
    chk("R1 epc", epc, 32'd0);
    chk("R1 esr", esr, 32'd0);
    chk("R1 nds", {31'd0, nds}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    compare_all();
    // R2 / R3 each class, ds low and high, prefix low/high (R6)
    step(1, 5'h0D, 32'h0000_1000, 0, 0, 32'h0000_0001, 0);
    step(1, 5'h0C, 32'h0000_2000, 1, 0, 32'h0000_4000, 0);
    step(1, 5'h02, 32'h0000_3000, 0, 0, 32'h0000_4000, 0);
    step(1, 5'h06, 32'h0000_3004, 1, 0, 32'h0000_0000, 0);
    step(1, 5'h07, 32'h0000_0000, 1, 0, 32'h0000_6000, 0);  // PC-4 wraps
    step(1, 5'h0B, 32'h0000_4444, 0, 0, 32'h0000_2000, 0);
    // R4 reset cause keeps epc
    step(1, 5'h01, 32'h1234_5678, 0, 0, 32'h0000_4000, 0);
    // R9 return
    step(0, 5'h00, 32'h0, 0, 1, 32'h0, 0);
    // R10 set then cleared by return despite set
    step(0, 5'h00, 32'h0, 0, 0, 32'h0, 1);
    step(0, 5'h00, 32'h0, 0, 1, 32'h0, 1);
    // R7 trap with nds pending; R8 bad cause
    step(0, 5'h00, 32'h0, 0, 0, 32'h0, 1);
    step(1, 5'h0E, 32'hCAFE_0000, 0, 0, 32'hFFFF_FFFF, 0);
    step(1, 5'h1F, 32'hBEEF_0000, 1, 1, 32'hFFFF_FFFF, 0);
    step(1, 5'h00, 32'hBEEF_0004, 0, 0, 32'h0, 0);
    // R11 entry beats return
    step(1, 5'h0D, 32'h0000_8000, 0, 1, 32'h0000_4000, 1);
    step(0, 5'h00, 32'h0, 0, 0, 32'h0, 0);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [4:0] c;
      c = ($urandom % 3 == 0) ? 5'($urandom) : 5'({$urandom % 8} == 0 ? 5'h0E : 5'h0D - 5'($urandom % 12));
      step($urandom % 3 == 0, c, $urandom, $urandom % 2 == 0, $urandom % 4 == 0,
           $urandom, $urandom % 3 == 0);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=0 exp=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule